// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This block performs one iteration of a non-restoring binary division per issued operation, together with the two setup operations that prepare the division flags. It works on three one-bit flags: Q (the sign of the partial remainder), M (the sign of the divisor) and T (the quotient bit and the bit shifted into the remainder). The flag register lives outside the block, next to the rest of the processor state. The block takes the current flags in, and the caller writes the updated flags back.

Software runs a whole division. It issues a setup operation first. It then issues one step for each quotient bit, and between steps it rotates the low dividend word through T, so that dividend bits enter the remainder and quotient bits leave it. Every operation is qualified by a valid strobe and finishes in one clock. The results are registered and appear in the cycle after the strobe.

Top module: `divstep_unit`

## Requirements
- R1: While reset is asserted and after it is released, valid_o is 0 and rem_o, q_o, m_o and t_o are all 0 until the first valid operation.
- R2: valid_o equals valid_i delayed by one clock, and the results of an operation appear on the outputs in that same cycle.
- R3: While valid_i is 0, rem_o, q_o, m_o and t_o keep their values, whatever the other inputs do.
- R4: Operation encoding on op_i: 2'b00 is a step, 2'b01 is unsigned setup, 2'b10 is signed setup, and 2'b11 is a pass operation that returns rn_i and the input flags unchanged.
- R5: Unsigned setup clears Q, M and T and returns rn_i unchanged on rem_o.
- R6: Signed setup sets Q to bit W-1 of rn_i, M to bit W-1 of rm_i and T to Q XOR M, and returns rn_i unchanged on rem_o.
- R7: A step takes the new Q from bit W-1 of rn_i, and shifts rn_i left by one with t_i entering bit 0.
- R8: A step uses the direction q_i XOR m_i. With direction 0 it subtracts rm_i from the shifted value, and a borrow is flagged when the result is greater than the shifted value. With direction 1 it adds rm_i, and a carry is flagged when the result is less than the shifted value. The result is driven on rem_o.
- R9: After a step, q_o is the new Q XOR m_i XOR the carry/borrow bit, and m_o equals m_i.
- R10: After a step, t_o is 1 when q_o equals m_o, and 0 otherwise.
- R11: For a 2W-bit unsigned dividend {hi, lo} with hi < divisor, the following sequence leaves the quotient in lo: unsigned setup, then W repetitions of (rotate lo left through T, then step on hi), then one final rotate of lo through T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Qualifies op_i and the operands |
| op_i | input | 2 | Operation code |
| rn_i | input | W | Dividend / partial remainder |
| rm_i | input | W | Divisor |
| q_i | input | 1 | Current Q flag |
| m_i | input | 1 | Current M flag |
| t_i | input | 1 | Current T flag |
| valid_o | output | 1 | Results valid |
| rem_o | output | W | Updated partial remainder |
| q_o | output | 1 | Updated Q flag |
| m_o | output | 1 | Updated M flag |
| t_o | output | 1 | Updated T flag |

## Verification
The bench runs complete unsigned divisions over every divisor of an 8-bit configuration. It uses zero and non-zero high words, including the largest legal high word, divisor minus one. A design that tested the wrong overflow condition, or chose the direction from the new Q instead of the old one, would return wrong quotient bits. Single steps are also swept with all eight flag combinations and with operands next to the wrap boundary, where the result equals the shifted value or wraps to it. In those cases a strict-versus-non-strict comparison error flips Q and T. Setup operations with divisors and dividends of both signs check the sign capture, and idle cycles with changing inputs catch outputs that do not hold.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  typedef enum logic [1:0] {
    DS_STEP = 2'b00,
    DS_SETU = 2'b01,
    DS_SETS = 2'b10,
    DS_PASS = 2'b11
  } ds_op_e;

  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } ds_flags_t;
endpackage

// File: rtl/divstep_setup.sv
module divstep_setup #(
  parameter int W = 32
) (
  input  logic                    sign_i,
  input  logic [W-1:0]            rn_i,
  input  logic [W-1:0]            rm_i,
  output divstep_pkg::ds_flags_t  flags_o
);
  localparam int MSB = W - 1;

  always_comb begin
    if (sign_i) begin
      flags_o.q = rn_i[MSB];
      flags_o.m = rm_i[MSB];
      flags_o.t = rn_i[MSB] ^ rm_i[MSB];
    end else begin
      flags_o = '0;
    end
  end
endmodule

// File: rtl/divstep_addsub.sv
module divstep_addsub #(
  parameter int W         = 32,
  parameter bit WIDE_CARRY = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  generate
    if (WIDE_CARRY) begin : g_wide
      logic [W:0] sum;
      always_comb begin
        sum   = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
        res_o = sum[W-1:0];
        cy_o  = sum[W];
      end
    end else begin : g_cmp
      // overflow recovered by comparing result against the operand
      always_comb begin
        res_o = sub_i ? (a_i - b_i) : (a_i + b_i);
        cy_o  = sub_i ? (res_o > a_i) : (res_o < a_i);
      end
    end
  endgenerate
endmodule

// File: rtl/divstep_core.sv
module divstep_core #(
  parameter int W          = 32,
  parameter bit WIDE_CARRY = 1'b0
) (
  input  logic [W-1:0]           rn_i,
  input  logic [W-1:0]           rm_i,
  input  divstep_pkg::ds_flags_t flags_i,
  output logic [W-1:0]           rem_o,
  output divstep_pkg::ds_flags_t flags_o
);
  localparam int MSB = W - 1;

  logic         dir_add;
  logic         q_shift;
  logic [W-1:0] shifted;
  logic         cy;
  logic         q_new;

  assign dir_add = flags_i.q ^ flags_i.m;
  assign q_shift = rn_i[MSB];
  assign shifted = {rn_i[MSB-1:0], flags_i.t};

  divstep_addsub #(.W(W), .WIDE_CARRY(WIDE_CARRY)) u_addsub (
    .a_i  (shifted),
    .b_i  (rm_i),
    .sub_i(~dir_add),
    .res_o(rem_o),
    .cy_o (cy)
  );

  assign q_new     = q_shift ^ flags_i.m ^ cy;
  assign flags_o.q = q_new;
  assign flags_o.m = flags_i.m;
  assign flags_o.t = (q_new == flags_i.m);
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit #(
  parameter int W          = 32,
  parameter bit WIDE_CARRY = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] rm_i,
  input  logic         q_i,
  input  logic         m_i,
  input  logic         t_i,
  output logic         valid_o,
  output logic [W-1:0] rem_o,
  output logic         q_o,
  output logic         m_o,
  output logic         t_o
);
  import divstep_pkg::*;

  ds_op_e       op;
  ds_flags_t    flags_in, setup_flags, step_flags, flags_nxt, flags_q;
  logic [W-1:0] step_rem, rem_nxt, rem_q;

  assign op       = ds_op_e'(op_i);
  assign flags_in = '{q: q_i, m: m_i, t: t_i};

  divstep_setup #(.W(W)) u_setup (
    .sign_i (op == DS_SETS),
    .rn_i   (rn_i),
    .rm_i   (rm_i),
    .flags_o(setup_flags)
  );

  divstep_core #(.W(W), .WIDE_CARRY(WIDE_CARRY)) u_core (
    .rn_i   (rn_i),
    .rm_i   (rm_i),
    .flags_i(flags_in),
    .rem_o  (step_rem),
    .flags_o(step_flags)
  );

  always_comb begin
    unique case (op)
      DS_STEP: begin rem_nxt = step_rem; flags_nxt = step_flags;  end
      DS_SETU,
      DS_SETS: begin rem_nxt = rn_i;     flags_nxt = setup_flags; end
      default: begin rem_nxt = rn_i;     flags_nxt = flags_in;    end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rem_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        rem_q   <= rem_nxt;
        flags_q <= flags_nxt;
      end
    end
  end

  assign rem_o = rem_q;
  assign q_o   = flags_q.q;
  assign m_o   = flags_q.m;
  assign t_o   = flags_q.t;

  a_r2_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(rem_o) && $stable(q_o) && $stable(m_o) && $stable(t_o));
  a_r5_unsigned_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b01 |=> !q_o && !m_o && !t_o && rem_o == $past(rn_i));
  a_r6_signed_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b10 |=> t_o == (q_o ^ m_o) && m_o == $past(rm_i[W-1]));
  a_r9_m_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b00 |=> m_o == $past(m_i));
  a_r10_t_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'b00 |=> t_o == (q_o == m_o));
endmodule

// File: tb/divstep_unit_tb.sv
module divstep_unit_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] rn_i = '0, rm_i = '0;
  logic         q_i = 1'b0, m_i = 1'b0, t_i = 1'b0;
  logic         valid_o;
  logic [W-1:0] rem_o;
  logic         q_o, m_o, t_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  divstep_unit #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .rn_i(rn_i), .rm_i(rm_i), .q_i(q_i), .m_i(m_i), .t_i(t_i),
    .valid_o(valid_o), .rem_o(rem_o), .q_o(q_o), .m_o(m_o), .t_o(t_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one operation: drive at negedge, result visible at the next negedge
  task automatic issue(input logic [1:0] op, input logic [W-1:0] rn, input logic [W-1:0] rm,
                       input logic q, input logic m, input logic t);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; rn_i = rn; rm_i = rm; q_i = q; m_i = m; t_i = t;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // arithmetic reference for one step, written from R7..R10
  function automatic logic [W+2:0] ref_step(input logic [W-1:0] rn, input logic [W-1:0] rm,
                                            input logic q, input logic m, input logic t);
    int unsigned sh, r, mod;
    logic qs, cy, qn;
    mod = 1 << W;
    qs  = rn[W-1];
    sh  = ((int'(rn) * 2) % mod) + int'(t);
    if (q ^ m) begin
      r  = (sh + rm) % mod;
      cy = (sh + rm) >= mod;
    end else begin
      r  = (sh + mod - rm) % mod;
      cy = rm > sh;
    end
    qn = qs ^ m ^ cy;
    return {r[W-1:0], qn, m, (qn == m)};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W+2:0] e;
    // R1 reset state
    #35;
    check("R1 valid_o", valid_o, 0);
    check("R1 rem_o", rem_o, 0);
    check("R1 flags", {q_o, m_o, t_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {valid_o, rem_o, q_o, m_o, t_o}, 0);

    // R2 valid timing
    @(negedge clk);
    valid_i = 1'b1; op_i = 2'b11; rn_i = 8'h5A; rm_i = 8'h00; q_i = 1; m_i = 0; t_i = 1;
    check("R2 not before edge", valid_o, 0);
    @(negedge clk);
    valid_i = 1'b0;
    check("R2 valid_o", valid_o, 1);
    check("R4 pass rem", rem_o, 8'h5A);
    check("R4 pass flags", {q_o, m_o, t_o}, 3'b101);
    @(negedge clk);
    check("R2 valid_o drop", valid_o, 0);

    // R3 hold with changing inputs while idle
    rn_i = 8'hFF; rm_i = 8'h01; op_i = 2'b01; q_i = 0; m_i = 1; t_i = 0;
    @(negedge clk);
    check("R3 hold rem", rem_o, 8'h5A);
    check("R3 hold flags", {q_o, m_o, t_o}, 3'b101);

    // R5 unsigned setup
    issue(2'b01, 8'hC3, 8'h81, 1, 1, 1);
    check("R5 flags cleared", {q_o, m_o, t_o}, 0);
    check("R5 rem", rem_o, 8'hC3);

    // R6 signed setup over sign combinations
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        logic [W-1:0] dn, dv;
        dn = a ? 8'h90 : 8'h10;
        dv = b ? 8'hF3 : 8'h03;
        issue(2'b10, dn, dv, 0, 0, 0);
        check("R6 flags", {q_o, m_o, t_o}, {a[0], b[0], a[0] ^ b[0]});
        check("R6 rem", rem_o, dn);
      end
    end

    // R7..R10 single-step sweep: all flag combinations, boundary and random operands
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < 40; k++) begin
        logic [W-1:0] a, b;
        case (k)
          0: begin a = 8'h00; b = 8'h00; end
          1: begin a = 8'hFF; b = 8'hFF; end
          2: begin a = 8'h80; b = 8'h01; end
          3: begin a = 8'h7F; b = 8'h00; end
          4: begin a = 8'h40; b = 8'h80; end
          5: begin a = 8'hC0; b = 8'h80; end
          default: begin a = W'($urandom); b = W'($urandom); end
        endcase
        issue(2'b00, a, b, f[2], f[1], f[0]);
        e = ref_step(a, b, f[2], f[1], f[0]);
        check("R7 R8 step rem", rem_o, e[W+2:3]);
        check("R9 step q m", {q_o, m_o}, e[2:1]);
        check("R10 step t", t_o, e[0]);
      end
    end

    // R11 full unsigned divisions using the block's own outputs as flag state
    for (int dv = 1; dv < 256; dv++) begin
      for (int h = 0; h < 2; h++) begin
        for (int lo_i = 0; lo_i < 256; lo_i += 37) begin
          logic [W-1:0] hi, lo;
          logic q, m, t, nt;
          logic [15:0] dividend;
          hi = h ? W'(dv - 1) : '0;
          lo = W'(lo_i);
          dividend = {hi, lo};
          issue(2'b01, hi, W'(dv), 0, 0, 0);
          q = q_o; m = m_o; t = t_o;
          for (int s = 0; s < W; s++) begin
            nt = lo[W-1];
            lo = {lo[W-2:0], t};
            t = nt;
            issue(2'b00, hi, W'(dv), q, m, t);
            hi = rem_o; q = q_o; m = m_o; t = t_o;
          end
          lo = {lo[W-2:0], t};
          check("R11 quotient", lo, 32'(dividend / dv));
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule